// File: doc/BRIEF.md
# Block-transfer address sequencer for multi-register loads and stores

This block turns one load-multiple or store-multiple request into a series of word transfers, one per cycle. A request brings a base address, a 16-bit register list, a two-bit addressing mode, a writeback flag and a load/store flag. For every set bit of the list the block issues a word-aligned address with the register index. Indices go from lowest to highest, and addresses rise in steps of four bytes. After the last transfer it presents the updated base pointer for one cycle. The memory port and the register file stay outside; they consume the transfer stream and the completion strobe.

The mode is read in one of two ways. In raw form, bit 1 selects increment (1) or decrement (0) and bit 0 selects before (1) or after (0). In stack form, bit 1 selects ascending (1) or descending (0) and bit 0 selects full (1) or empty (0). The block converts a stack name into a raw mode. The conversion differs for loads and stores, so that a pop undoes the matching push. Two qualifiers travel with the request. One routes the transfers to the user-mode register bank. The other, on a load that includes the program counter, requests a copy of the saved status into the current status.

The controller has three states. SEQ_IDLE accepts `start`. SEQ_MOVE emits one transfer per cycle. SEQ_CLOSE emits the completion strobe. The transitions are:
- idle-to-move: `start` with a non-empty list.
- idle-to-close: `start` with an empty list.
- move-to-move: bits are still pending after the current transfer.
- move-to-close: the current transfer is the last.
- close-to-idle: always, after one cycle.

Top module: `blkxfer_seq`

## Requirements
- R1: A `start` seen in SEQ_IDLE with a non-empty list gives its first transfer (`xfer_valid`=1) in the next cycle. Transfers then come on consecutive cycles, one per set list bit, with `xfer_reg` equal to the set bit indices in ascending order and `xfer_load` equal to the request's load flag.
- R2: Each transfer address is 4 greater than the one before it within the same request.
- R3: With `stack_names`=0 and N set bits, the first address is: increment-after (mode 2'b10) base; increment-before (2'b11) base+4; decrement-after (2'b00) base-4N+4; decrement-before (2'b01) base-4N. Arithmetic wraps modulo 2^32.
- R4: With `stack_names`=1 on a store (`is_load`=0), the mode maps as follows: empty-ascending (2'b10) to increment-after; full-ascending (2'b11) to increment-before; empty-descending (2'b00) to decrement-after; full-descending (2'b01) to decrement-before.
- R5: With `stack_names`=1 on a load, the mode maps as follows: full-descending (2'b01) to increment-after; empty-descending (2'b00) to increment-before; full-ascending (2'b11) to decrement-after; empty-ascending (2'b10) to decrement-before.
- R6: One cycle after the last transfer, `done` is 1 for exactly one cycle. `base_we` equals the writeback flag. `new_base` is base+4N for increment modes and base-4N for decrement modes when writeback is set, and the unchanged base when it is clear.
- R7: An empty list produces no transfer. `done` rises in the cycle after `start`, and `new_base` equals the base.
- R8: Every transfer carries `xfer_user`=1 exactly when `user_bank` was set and list bit 15 (the program counter) was clear.
- R9: `status_restore` is 1 only in the `done` cycle, and only for a load with `user_bank` set and list bit 15 set.
- R10: `start` is ignored outside SEQ_IDLE. The running request's transfers and result are unchanged by it.
- R11: After reset the block is in SEQ_IDLE with `xfer_valid`, `done`, `base_we` and `status_restore` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only in SEQ_IDLE |
| base | input | 32 | Base pointer value |
| reg_list | input | 16 | Register select list, bit i selects register i |
| mode | input | 2 | Addressing mode, raw or stack form |
| stack_names | input | 1 | 1 when `mode` holds a stack discipline |
| wback | input | 1 | Write the updated base back |
| is_load | input | 1 | 1 for load, 0 for store |
| user_bank | input | 1 | Bank / exception-return qualifier |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_reg | output | 4 | Register index of the transfer |
| xfer_load | output | 1 | Direction of the transfer |
| xfer_user | output | 1 | Transfer targets the user-mode bank |
| done | output | 1 | Completion strobe |
| base_we | output | 1 | Base write enable, valid with `done` |
| new_base | output | 32 | Updated base value, valid with `done` |
| status_restore | output | 1 | Copy saved status into current status, valid with `done` |

## Verification
The embedded properties assume that a request is framed only by `start` in SEQ_IDLE. Under that assumption, the address step, the index order and the qualifier checks compare one transfer only with the transfer before it in the same request. Reset is the only other thing that ends a request, and the property gates turn off during reset. The stimulus holds every request field steady until the next negedge after `start`. It raises `start` during a transfer only to check that the block ignores it. Base values near zero exercise wrap-around of the decrement arithmetic.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_MOVE  = 2'd1,
        SEQ_CLOSE = 2'd2
    } seq_state_t;

    // Resolved addressing mode: direction of travel and adjust-before-access.
    typedef struct packed {
        logic incr;
        logic pre;
    } addr_mode_t;

endpackage

// File: rtl/blkxfer_mode_map.sv
module blkxfer_mode_map
    import blkxfer_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic       stack_names,
    input  logic       is_load,
    output addr_mode_t amode
);
    // Stack form: bit1 ascending, bit0 full.
    // A push (store) goes the way the stack grows; full means adjust first.
    // A pop (load) undoes the push, so both senses invert.
    always_comb begin
        if (stack_names && is_load) begin
            amode.incr = ~mode_code[1];
            amode.pre  = ~mode_code[0];
        end else begin
            amode.incr = mode_code[1];
            amode.pre  = mode_code[0];
        end
    end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec,
    output logic [IW-1:0]   idx
);
    // Scan downward so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blkxfer_popcount.sv
module blkxfer_popcount #(
    parameter int NREG = 16,
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] vec,
    output logic [CW-1:0]   count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  addr_mode_t    amode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count) * STEP;
        if (amode.incr) begin
            first_addr = amode.pre ? base + STEP : base;
            final_base = base + span;
        end else begin
            // Lowest register sits at the lowest address of the block.
            first_addr = amode.pre ? base - span : base - span + STEP;
            final_base = base - span;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1),
    localparam int PC_IDX    = NREG - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   base,
    input  logic [NREG-1:0] reg_list,
    input  logic [1:0]      mode,
    input  logic            stack_names,
    input  logic            wback,
    input  logic            is_load,
    input  logic            user_bank,
    output logic            xfer_valid,
    output logic [AW-1:0]   xfer_addr,
    output logic [IW-1:0]   xfer_reg,
    output logic            xfer_load,
    output logic            xfer_user,
    output logic            done,
    output logic            base_we,
    output logic [AW-1:0]   new_base,
    output logic            status_restore
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    seq_state_t      state, state_nx;
    addr_mode_t      amode;
    logic [CW-1:0]   req_count;
    logic [AW-1:0]   plan_first, plan_final;
    logic [IW-1:0]   pend_low;
    logic [NREG-1:0] pend_list, pend_rest;
    logic [AW-1:0]   cur_addr, base_q, final_q;
    logic            wback_q, load_q, user_q, restore_q;
    logic            accept;

    blkxfer_mode_map u_map (
        .mode_code  (mode),
        .stack_names(stack_names),
        .is_load    (is_load),
        .amode      (amode)
    );

    blkxfer_popcount #(.NREG(NREG)) u_count (
        .vec  (reg_list),
        .count(req_count)
    );

    blkxfer_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base      (base),
        .count     (req_count),
        .amode     (amode),
        .first_addr(plan_first),
        .final_base(plan_final)
    );

    blkxfer_lowbit #(.NREG(NREG)) u_low (
        .vec(pend_list),
        .idx(pend_low)
    );

    assign accept    = (state == SEQ_IDLE) && start;
    assign pend_rest = pend_list & (pend_list - NREG'(1));

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (start) state_nx = (|reg_list) ? SEQ_MOVE : SEQ_CLOSE;
            SEQ_MOVE:  if (pend_rest == '0) state_nx = SEQ_CLOSE;
            SEQ_CLOSE: state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // Request context and walking address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_list <= '0;
            cur_addr  <= '0;
            base_q    <= '0;
            final_q   <= '0;
            wback_q   <= 1'b0;
            load_q    <= 1'b0;
            user_q    <= 1'b0;
            restore_q <= 1'b0;
        end else if (accept) begin
            pend_list <= reg_list;
            cur_addr  <= plan_first;
            base_q    <= base;
            final_q   <= plan_final;
            wback_q   <= wback;
            load_q    <= is_load;
            user_q    <= user_bank & ~reg_list[PC_IDX];
            restore_q <= is_load & user_bank & reg_list[PC_IDX];
        end else if (state == SEQ_MOVE) begin
            pend_list <= pend_rest;
            cur_addr  <= cur_addr + STEP;
        end
    end

    // Outputs by state.
    always_comb begin
        xfer_valid     = 1'b0;
        xfer_addr      = cur_addr;
        xfer_reg       = pend_low;
        xfer_load      = load_q;
        xfer_user      = 1'b0;
        done           = 1'b0;
        base_we        = 1'b0;
        new_base       = wback_q ? final_q : base_q;
        status_restore = 1'b0;
        unique case (state)
            SEQ_IDLE: ;
            SEQ_MOVE: begin
                xfer_valid = 1'b1;
                xfer_user  = user_q;
            end
            SEQ_CLOSE: begin
                done           = 1'b1;
                base_we        = wback_q;
                status_restore = restore_q;
            end
            default: ;
        endcase
    end

    // Consecutive transfers of one request step by one word.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_addr == $past(xfer_addr) + STEP));

    // Register indices strictly rise within a request.
    assert_reg_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_reg > $past(xfer_reg)));

    // Bank qualifier stays fixed across a request.
    assert_user_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> $stable(xfer_user));

    // Completion is a single-cycle pulse, never overlapping a transfer.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && xfer_valid));
    assert_base_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> done);

    // Status restore only with completion and only after a load.
    assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> (done && xfer_load));

    // A new transfer stream cannot begin straight after completion.
    assert_close_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !xfer_valid);

endmodule

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] reg_list = '0;
    logic [1:0]  mode = '0;
    logic        stack_names = 1'b0;
    logic        wback = 1'b0;
    logic        is_load = 1'b0;
    logic        user_bank = 1'b0;
    logic        xfer_valid, xfer_load, xfer_user, done, base_we, status_restore;
    logic [31:0] xfer_addr, new_base;
    logic [3:0]  xfer_reg;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    blkxfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .reg_list(reg_list),
        .mode(mode), .stack_names(stack_names), .wback(wback), .is_load(is_load),
        .user_bank(user_bank), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .xfer_reg(xfer_reg), .xfer_load(xfer_load), .xfer_user(xfer_user),
        .done(done), .base_we(base_we), .new_base(new_base),
        .status_restore(status_restore)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one request, compared on every cycle.
    task automatic run_op(input logic [31:0] b, input logic [15:0] lst,
                          input logic [1:0] md, input logic stk, input logic wb,
                          input logic ld, input logic usr, input logic poke);
        bit inc, pre;
        int n = 0;
        int regs[$];
        logic [31:0] a, fin;
        string mtag;
        mtag = stk ? (ld ? "R5" : "R4") : "R3";
        // Stack form: bit1 ascending, bit0 full; loads invert both senses.
        if (stk && ld) begin inc = !md[1]; pre = !md[0]; end
        else           begin inc = md[1];  pre = md[0];  end
        for (int i = 0; i < 16; i++) if (lst[i]) begin n++; regs.push_back(i); end
        if (inc) begin a = pre ? b + 4 : b;            fin = b + 32'(4 * n); end
        else     begin a = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 4; fin = b - 32'(4 * n); end

        @(negedge clk);
        base = b; reg_list = lst; mode = md; stack_names = stk;
        wback = wb; is_load = ld; user_bank = usr; start = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R1", "xfer_valid", 32'(xfer_valid), 32'd1);
            chk("R1", "xfer_reg", 32'(xfer_reg), 32'(regs[k]));
            chk("R1", "xfer_load", 32'(xfer_load), 32'(ld));
            chk(k == 0 ? mtag : "R2", "xfer_addr", xfer_addr, a + 32'(4 * k));
            chk("R8", "xfer_user", 32'(xfer_user), 32'(usr & !lst[15]));
            chk("R6", "done_early", 32'(done), 32'd0);
            if (poke && k == 0) begin
                // R10: a second start mid-request must change nothing.
                start = 1'b1; base = 32'hDEAD_0000; reg_list = 16'h0003;
                mode = ~md; is_load = !ld; wback = !wb;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk(n == 0 ? "R7" : "R6", "done", 32'(done), 32'd1);
        chk(n == 0 ? "R7" : "R6", "xfer_valid_at_done", 32'(xfer_valid), 32'd0);
        chk("R6", "base_we", 32'(base_we), 32'(wb));
        chk(n == 0 ? "R7" : "R6", "new_base", new_base, wb ? fin : b);
        chk("R9", "status_restore", 32'(status_restore), 32'(ld & usr & lst[15]));
        @(negedge clk);
        chk("R6", "done_pulse", 32'(done), 32'd0);
        chk(poke ? "R10" : "R1", "idle_valid", 32'(xfer_valid), 32'd0);
        chk("R9", "restore_pulse", 32'(status_restore), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "xfer_valid", 32'(xfer_valid), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "base_we", 32'(base_we), 32'd0);
        chk("R11", "status_restore", 32'(status_restore), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle_after_release", 32'(xfer_valid | done), 32'd0);

        // R3 raw modes
        run_op(32'h0000_1000, 16'h00F1, 2'b10, 0, 1, 0, 0, 0);
        run_op(32'h0000_1000, 16'h00F1, 2'b11, 0, 1, 1, 0, 0);
        run_op(32'h0000_1000, 16'h00F1, 2'b00, 0, 1, 0, 0, 0);
        run_op(32'h0000_1000, 16'h00F1, 2'b01, 0, 0, 1, 0, 0);
        // R4 stack names, stores
        run_op(32'h0000_2000, 16'h4821, 2'b01, 1, 1, 0, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b11, 1, 1, 0, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b00, 1, 1, 0, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b10, 1, 1, 0, 0, 0);
        // R5 stack names, loads
        run_op(32'h0000_2000, 16'h4821, 2'b01, 1, 1, 1, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b00, 1, 1, 1, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b11, 1, 1, 1, 0, 0);
        run_op(32'h0000_2000, 16'h4821, 2'b10, 1, 1, 1, 0, 0);
        // R7 empty list
        run_op(32'h0000_3000, 16'h0000, 2'b01, 0, 1, 0, 0, 0);
        // R8 / R9 qualifiers
        run_op(32'h0000_4000, 16'h0006, 2'b10, 0, 0, 0, 1, 0);
        run_op(32'h0000_4000, 16'h80F0, 2'b01, 1, 1, 1, 1, 0);
        run_op(32'h0000_4000, 16'h80F0, 2'b01, 1, 1, 0, 1, 0);
        // R10 start while busy, full list and single entry
        run_op(32'h0000_5000, 16'hFFFF, 2'b11, 0, 1, 1, 0, 1);
        run_op(32'h0000_5000, 16'h8000, 2'b00, 0, 1, 0, 0, 1);
        // R3 wrap-around below zero
        run_op(32'h0000_0004, 16'h0007, 2'b01, 0, 1, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule